// File: doc/BRIEF.md
# Debug Instruction Injection Unit

This unit pushes instruction and data words into the pipeline of a halted processor core through that core's 33-bit instruction scan chain. For each injection it first asks a neighbouring chain selector to put scan chain 1 behind the INTEST instruction. It then walks the JTAG state machine itself, one TCK step per clock. The walk goes from Run-Test/Idle into Shift-DR, shifts a breakpoint-speed bit followed by the 32-bit word, and comes back through Update-DR to Run-Test/Idle, so that the word is clocked into the pipeline. While the word is shifted in, the unit collects the 32 bits the chain shifts out and presents them as the result.

On top of single injections, the unit runs a fixed macro that reads a core register. The macro is a sequence of six debug-speed injections, and the word captured on the last one is returned. The unit also keeps two saturating counters, one for debug-speed injections and one for system-speed injections. Software clears both when it records a new halt. Commands arrive on a one-cycle command port. A command is taken only while the unit is idle, and `done` pulses once the final word has been captured.

Top module: `dbg_inject`

## Requirements
- R1: Every injection begins with `chain1_req` held high until a one-cycle `chain1_ack`. No TCK step (`jt_step`) is issued while the request is pending. The first step follows in the cycle after the acknowledge.
- R2: An injection is exactly 38 consecutive steps, starting and ending in Run-Test/Idle. TMS is 1, 0, 0, then 33 shift steps with TMS 0 except 1 on the 33rd, then 1 (Update-DR), then 0 (Run-Test/Idle).
- R3: The first shifted TDI bit is the breakpoint-speed bit: 1 for system speed, 0 for debug speed. Word bits 31 down to 0 follow, most significant first.
- R4: The result holds the TDO bits seen on shift steps 2 to 33, with the bit of step 2 in result bit 31. The bit seen during the breakpoint step is dropped.
- R5: Command code 0 (inject) performs one injection of `cmd_word` with breakpoint bit `cmd_sys`. `done` is high for exactly one cycle, in the cycle after the 38th step. `result` is valid then and holds until the next completion.
- R6: Command code 1 (register read) performs six injections, all with breakpoint bit 0. The words are, in order: NOP, then the store base opcode with bits 15:12 replaced by `cmd_reg`, then four NOPs. The result is the word captured on the sixth injection. The defaults are NOP = E1A00000h and store base = E58E0000h.
- R7: At the end of each injection, `sys_cnt` adds one if the breakpoint bit was 1; otherwise `dbg_cnt` adds one.
- R8: Each counter stops at 2^CNT_W-1 and does not wrap.
- R9: Command code 2 (clear), taken while idle, sets both counters to 0 in the next cycle. It starts no injection and gives no `done`. Command code 3 does nothing.
- R10: A command presented while `busy` is high is ignored: it adds no injection and changes no counter or result.
- R11: After reset, `busy`, `done`, `chain1_req` and `jt_step` are 0, and `result` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one TCK step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 inject, 1 register read, 2 clear counters, 3 none |
| cmd_word | input | 32 | Word to inject |
| cmd_sys | input | 1 | Breakpoint-speed bit for an inject command |
| cmd_reg | input | 4 | Register number for a register read |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Last captured word |
| dbg_cnt | output | 8 | Debug-speed injections since clear |
| sys_cnt | output | 8 | System-speed injections since clear |
| chain1_req | output | 1 | Request to select chain 1 with INTEST |
| chain1_ack | input | 1 | Selector acknowledge, one cycle |
| jt_step | output | 1 | A TCK step happens at the next edge |
| jt_tms | output | 1 | TMS for this step |
| jt_tdi | output | 1 | TDI for this step |
| jt_tdo | input | 1 | TDO sampled at this step |

## Verification
A step index that drifts inside the walker shows up within the same injection. It appears at the pins as a TMS pattern that leaves the 38-step shape, or as a shifted vector that is rotated by one bit. A wrong slot count in the register-read macro shows up at the end of the sixth injection. It appears as an extra or missing injection, a wrong word in the second slot, or a result taken from the wrong capture. A counter fault shows up on `dbg_cnt` or `sys_cnt` in the cycle after the injection that triggers it.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
   typedef enum logic [1:0] {
      OP_INJECT  = 2'd0,
      OP_READREG = 2'd1,
      OP_CLEAR   = 2'd2,
      OP_NONE    = 2'd3
   } inj_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEL  = 2'd1,
      SQ_RUN  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/dbg_inject_satcnt.sv
module dbg_inject_satcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (clr)                      cnt <= '0;
      else if (inc && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == CNT_MAX) && inc && !clr |=> cnt == CNT_MAX); // R8
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == '0); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !clr && !inc |=> $stable(cnt)); // R7
endmodule

// File: rtl/dbg_inject_walker.sv
module dbg_inject_walker #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W:0]   vec_in,
   input  logic              tdo,
   output logic              step,
   output logic              tms,
   output logic              tdi,
   output logic              fin,
   output logic [WORD_W-1:0] cap
);
   localparam int VEC_W  = WORD_W + 1;
   localparam int PRE    = 3;
   localparam int SH_END = PRE + VEC_W - 1;
   localparam int LAST   = SH_END + 2;
   localparam int IDX_W  = $clog2(LAST + 1);
   localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE);
   localparam logic [IDX_W-1:0] I_SEND = IDX_W'(SH_END);
   localparam logic [IDX_W-1:0] I_UPD  = IDX_W'(SH_END + 1);
   localparam logic [IDX_W-1:0] I_LAST = IDX_W'(LAST);

   logic             active;
   logic [IDX_W-1:0] idx;
   logic [VEC_W-1:0] sh;
   logic             in_shift;

   initial begin
      assert (WORD_W >= 2) else $error("WORD_W too small");
   end

   assign in_shift = active && (idx >= I_PRE) && (idx <= I_SEND);
   assign step     = active;
   assign tdi      = in_shift & sh[VEC_W-1];
   assign fin      = active && (idx == I_LAST);

   always_comb begin
      if (!active)          tms = 1'b0;
      else if (idx == '0)   tms = 1'b1;
      else if (in_shift)    tms = (idx == I_SEND);
      else if (idx == I_UPD) tms = 1'b1;
      else                  tms = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         sh     <= '0;
         cap    <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         sh     <= vec_in;
      end else if (active) begin
         if (in_shift) begin
            sh  <= {sh[VEC_W-2:0], 1'b0};
            cap <= {cap[WORD_W-2:0], tdo};
         end
         if (idx == I_LAST) begin
            active <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !active); // R1
   AST_STEP_RUN: assert property (@(posedge clk) disable iff (!rst_n) active && !fin |=> active); // R2
endmodule

// File: rtl/dbg_inject_seq.sv
module dbg_inject_seq
   import dbg_inject_pkg::*;
#(
   parameter int              WORD_W   = 32,
   parameter int              REG_W    = 4,
   parameter int              REG_LSB  = 12,
   parameter logic [WORD_W-1:0] NOP_OP  = 32'hE1A0_0000,
   parameter logic [WORD_W-1:0] STR_OP  = 32'hE58E_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic              cmd_sys,
   input  logic [REG_W-1:0]  cmd_reg,
   input  logic              chain1_ack,
   input  logic              walk_active,
   input  logic              fin,
   input  logic [WORD_W-1:0] cap,
   output logic              start,
   output logic [WORD_W:0]   vec,
   output logic              chain1_req,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] result,
   output logic [1:0]        cnt_inc,
   output logic              cnt_clr
);
   localparam int SLOTS  = 6;
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [SLOT_W-1:0] SLOT_STR  = SLOT_W'(1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
   localparam logic [WORD_W-1:0] FIELD_MASK =
      ((WORD_W'(1) << REG_W) - WORD_W'(1)) << REG_LSB;

   seq_st_e            st;
   logic               rd_q;
   logic               sys_q;
   logic [WORD_W-1:0]  word_q;
   logic [REG_W-1:0]   reg_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [WORD_W-1:0]  str_word;
   logic [WORD_W-1:0]  cur_word;
   logic               cur_bk;
   logic               last_slot;
   logic               accept;

   initial begin
      assert (REG_LSB + REG_W <= WORD_W) else $error("register field outside word");
   end

   assign str_word  = (STR_OP & ~FIELD_MASK) | (WORD_W'(reg_q) << REG_LSB);
   assign cur_word  = !rd_q ? word_q : ((slot_q == SLOT_STR) ? str_word : NOP_OP);
   assign cur_bk    = !rd_q && sys_q;
   assign vec       = {cur_bk, cur_word};
   assign last_slot = !rd_q || (slot_q == SLOT_LAST);
   assign busy       = (st != SQ_IDLE);
   assign chain1_req = (st == SQ_SEL);
   assign start      = (st == SQ_SEL) && chain1_ack;
   assign accept     = (st == SQ_IDLE) && cmd_valid;
   assign cnt_clr    = accept && (inj_op_e'(cmd_op) == OP_CLEAR);
   assign cnt_inc[0] = (st == SQ_RUN) && fin && !cur_bk;
   assign cnt_inc[1] = (st == SQ_RUN) && fin && cur_bk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         rd_q   <= 1'b0;
         sys_q  <= 1'b0;
         word_q <= '0;
         reg_q  <= '0;
         slot_q <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (accept && (inj_op_e'(cmd_op) == OP_INJECT)) begin
                  rd_q   <= 1'b0;
                  word_q <= cmd_word;
                  sys_q  <= cmd_sys;
                  slot_q <= '0;
                  st     <= SQ_SEL;
               end else if (accept && (inj_op_e'(cmd_op) == OP_READREG)) begin
                  rd_q   <= 1'b1;
                  reg_q  <= cmd_reg;
                  sys_q  <= 1'b0;
                  slot_q <= '0;
                  st     <= SQ_SEL;
               end
            end
            SQ_SEL: if (chain1_ack) st <= SQ_RUN;
            SQ_RUN: begin
               if (fin) begin
                  if (last_slot) begin
                     st     <= SQ_IDLE;
                     done   <= 1'b1;
                     result <= cap;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                     st     <= SQ_SEL;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_REQ_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) chain1_req |-> !walk_active); // R1
   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
   AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !walk_active); // R5
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == SQ_RUN) && rd_q |-> !cnt_inc[1]); // R6
   AST_BUSY_IGN: assert property (@(posedge clk) disable iff (!rst_n) busy && cmd_valid && !fin |=> $stable(result)); // R10
endmodule

// File: rtl/dbg_inject.sv
module dbg_inject
   import dbg_inject_pkg::*;
#(
   parameter int                WORD_W  = 32,
   parameter int                REG_W   = 4,
   parameter int                REG_LSB = 12,
   parameter int                CNT_W   = 8,
   parameter logic [WORD_W-1:0] NOP_OP  = 32'hE1A0_0000,
   parameter logic [WORD_W-1:0] STR_OP  = 32'hE58E_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic              cmd_sys,
   input  logic [REG_W-1:0]  cmd_reg,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] result,
   output logic [CNT_W-1:0]  dbg_cnt,
   output logic [CNT_W-1:0]  sys_cnt,
   output logic              chain1_req,
   input  logic              chain1_ack,
   output logic              jt_step,
   output logic              jt_tms,
   output logic              jt_tdi,
   input  logic              jt_tdo
);
   logic              start;
   logic              fin;
   logic [WORD_W:0]   vec;
   logic [WORD_W-1:0] cap;
   logic [1:0]        cnt_inc;
   logic              cnt_clr;
   logic [CNT_W-1:0]  cnt_q [2];

   dbg_inject_seq #(
      .WORD_W(WORD_W), .REG_W(REG_W), .REG_LSB(REG_LSB),
      .NOP_OP(NOP_OP), .STR_OP(STR_OP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_word(cmd_word),
      .cmd_sys(cmd_sys), .cmd_reg(cmd_reg),
      .chain1_ack(chain1_ack), .walk_active(jt_step), .fin(fin), .cap(cap),
      .start(start), .vec(vec), .chain1_req(chain1_req), .busy(busy),
      .done(done), .result(result), .cnt_inc(cnt_inc), .cnt_clr(cnt_clr)
   );

   dbg_inject_walker #(.WORD_W(WORD_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec), .tdo(jt_tdo),
      .step(jt_step), .tms(jt_tms), .tdi(jt_tdi), .fin(fin), .cap(cap)
   );

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      dbg_inject_satcnt #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc[g]), .cnt(cnt_q[g])
      );
   end

   assign dbg_cnt = cnt_q[0];
   assign sys_cnt = cnt_q[1];

   AST_ONE_SPEED: assert property (@(posedge clk) disable iff (!rst_n) $countones({dbg_cnt != $past(dbg_cnt), sys_cnt != $past(sys_cnt)}) <= 1 || $past(cnt_clr)); // R7
endmodule

// File: tb/dbg_inject_bench.sv
module dbg_inject_bench;
   localparam int CW = 4;
   localparam logic [31:0] NOP = 32'hE1A0_0000;
   localparam logic [31:0] STB = 32'hE58E_0000;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [31:0] cmd_word = '0;
   logic cmd_sys = 1'b0;
   logic [3:0] cmd_reg = '0;
   logic busy, done, chain1_req, jt_step, jt_tms, jt_tdi, jt_tdo;
   logic [31:0] result;
   logic [CW-1:0] dbg_cnt, sys_cnt;
   logic chain1_ack = 1'b0;

   dbg_inject #(.CNT_W(CW)) u_dbg_inject (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_word(cmd_word), .cmd_sys(cmd_sys), .cmd_reg(cmd_reg),
      .busy(busy), .done(done), .result(result), .dbg_cnt(dbg_cnt), .sys_cnt(sys_cnt),
      .chain1_req(chain1_req), .chain1_ack(chain1_ack),
      .jt_step(jt_step), .jt_tms(jt_tms), .jt_tdi(jt_tdi), .jt_tdo(jt_tdo)
   );

   int total = 0;
   int bad = 0;
   int d_n = 0;
   int done_seen = 0;
   bit finished = 0;
   logic [32:0] vec_q[$];
   logic [31:0] res_q[$];

   function automatic logic [31:0] ret_word(int n);
      return ((32'(n) + 32'd1) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // chain selector: acknowledge two cycles after the request appears
   logic [1:0] ad = 2'd0;
   always @(posedge clk) begin
      if (!chain1_req) ad <= 2'd0;
      else if (ad != 2'd3) ad <= ad + 2'd1;
      chain1_ack <= chain1_req && (ad == 2'd2);
   end

   // TAP and scan chain model
   int m_pos = 0;
   int m_n = 0;
   logic granted = 1'b0;
   bit tms_ok = 1'b1;
   logic [32:0] m_cap = '0;
   logic [32:0] m_in = '0;

   assign jt_tdo = (m_pos >= 3 && m_pos <= 35) ? m_cap[35 - m_pos] : 1'b0;

   function automatic logic exp_tms(int p);
      if (p == 0) return 1'b1;
      if (p <= 2) return 1'b0;
      if (p <= 35) return (p == 35);
      return (p == 36);
   endfunction

   always @(posedge clk) begin
      if (chain1_req && chain1_ack) granted <= 1'b1;
      if (jt_step) begin
         if (jt_tms !== exp_tms(m_pos)) tms_ok <= 1'b0;
         if (m_pos == 1) m_cap <= {m_n[0], ret_word(m_n)};
         if (m_pos >= 3 && m_pos <= 35) m_in <= {m_in[31:0], jt_tdi};
         if (m_pos == 37) begin
            chk(granted, "R1 chain select before steps", 64'(granted), 64'd1);
            chk(tms_ok && jt_tms === 1'b0, "R2 tms walk", 64'(tms_ok), 64'd1);
            if (vec_q.size() == 0) chk(1'b0, "R10 unexpected injection", 64'(m_in), 64'd0);
            else begin
               logic [32:0] e;
               e = vec_q.pop_front();
               chk(m_in == e, "R3 shifted vector", 64'(m_in), 64'(e));
            end
            m_n <= m_n + 1;
            m_pos <= 0;
            granted <= 1'b0;
            tms_ok <= 1'b1;
         end else begin
            m_pos <= m_pos + 1;
         end
      end
   end

   // result monitor
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done) chk(1'b0, "R5 done wider than one cycle", 64'd2, 64'd1);
         if (done) begin
            done_seen++;
            if (res_q.size() == 0) chk(1'b0, "R5 unexpected done", 64'(result), 64'd0);
            else begin
               logic [31:0] e;
               e = res_q.pop_front();
               chk(result == e, "R4 R5 R6 captured result", 64'(result), 64'(e));
            end
         end
      end
      prev_done <= done;
   end

   task automatic issue(logic [1:0] op, logic [31:0] w, logic s, logic [3:0] r);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_sys = s; cmd_reg = r;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic inject(logic [31:0] w, logic s);
      while (busy) @(negedge clk);
      vec_q.push_back({s, w});
      res_q.push_back(ret_word(d_n));
      d_n++;
      issue(2'd0, w, s, 4'd0);
      wait_done();
   endtask

   task automatic read_reg(logic [3:0] r);
      logic [31:0] sw;
      while (busy) @(negedge clk);
      sw = (STB & ~32'h0000_F000) | (32'(r) << 12);
      vec_q.push_back({1'b0, NOP});
      vec_q.push_back({1'b0, sw});
      for (int i = 0; i < 4; i++) vec_q.push_back({1'b0, NOP});
      res_q.push_back(ret_word(d_n + 5));
      d_n += 6;
      issue(2'd1, 32'hFFFF_FFFF, 1'b1, r);
      wait_done();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 64'd0, 64'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !chain1_req && !jt_step, "R11 reset control outputs",
          64'({busy, done, chain1_req, jt_step}), 64'd0);
      chk(result == 0 && dbg_cnt == 0 && sys_cnt == 0, "R11 reset result and counters",
          64'({result, dbg_cnt, sys_cnt}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      inject(32'h1234_5678, 1'b0);
      inject(32'h8000_0001, 1'b1);
      read_reg(4'd3);
      read_reg(4'd15);
      chk(dbg_cnt == 13 && sys_cnt == 1, "R7 speed counters", 64'({dbg_cnt, sys_cnt}), 64'({4'd13, 4'd1}));
      inject(32'h0F0F_F0F0, 1'b0);
      inject(32'hFFFF_FFFF, 1'b0);
      chk(dbg_cnt == 15, "R8 counter reaches maximum", 64'(dbg_cnt), 64'd15);
      inject(32'h0000_0000, 1'b0);
      chk(dbg_cnt == 15, "R8 counter holds at maximum", 64'(dbg_cnt), 64'd15);
      inject(32'hDEAD_BEEF, 1'b1);
      chk(sys_cnt == 2 && dbg_cnt == 15, "R7 system speed count", 64'({dbg_cnt, sys_cnt}), 64'({4'd15, 4'd2}));

      // R9 clear, and command code 3
      issue(2'd2, 32'h0, 1'b0, 4'd0);
      chk(dbg_cnt == 0 && sys_cnt == 0 && !busy, "R9 clear zeroes counters",
          64'({busy, dbg_cnt, sys_cnt}), 64'd0);
      begin
         int dn0;
         dn0 = done_seen;
         issue(2'd3, 32'h5555_5555, 1'b1, 4'd7);
         chk(!busy && !chain1_req, "R9 code 3 starts nothing", 64'({busy, chain1_req}), 64'd0);
         repeat (60) @(negedge clk);
         chk(done_seen == dn0 && m_pos == 0 && vec_q.size() == 0,
             "R9 no injection or done after clear", 64'(done_seen - dn0), 64'd0);
      end

      // R10 command while busy is dropped
      vec_q.push_back({1'b0, 32'hCAFE_0001});
      res_q.push_back(ret_word(d_n));
      d_n++;
      issue(2'd0, 32'hCAFE_0001, 1'b0, 4'd0);
      repeat (5) @(negedge clk);
      chk(busy, "R10 busy during injection", 64'(busy), 64'd1);
      issue(2'd1, 32'h0, 1'b0, 4'd2);
      issue(2'd2, 32'h0, 1'b0, 4'd0);
      wait_done();
      repeat (120) @(negedge clk);
      chk(!busy && vec_q.size() == 0 && m_pos == 0, "R10 dropped command ran nothing",
          64'({busy, m_pos[7:0]}), 64'd0);
      chk(dbg_cnt == 1 && sys_cnt == 0, "R10 counters untouched by dropped clear",
          64'({dbg_cnt, sys_cnt}), 64'({4'd1, 4'd0}));

      read_reg(4'd0);
      chk(dbg_cnt == 7 && res_q.size() == 0, "R6 read macro six debug injections",
          64'(dbg_cnt), 64'd7);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule